// File: doc/BRIEF.md
# Serial Fast Command Receiver

This block listens to a single serial command line. The line is sampled on every rising edge of the 64 MHz system clock. The block looks for a fixed 8-bit framing pattern followed by an 8-bit command code. When it finds a known code, it raises one action strobe for a single system clock cycle. There are five actions:

- nudge the slow-clock edge later;
- start a front-end calibration;
- resynchronise the divider;
- swap the active control-bus channel;
- reset the chip, including the control-bus slave, which has no reset pin of its own.

The block also owns the clock divider that produces the 16 MHz and 2 MHz clock enables. The sync and nudge commands act directly on this divider, so the phase of the 2 MHz edge can be aligned across many chips from one shared command line.

A separate output selects which of the two redundant control-bus channels, primary or secondary, is in use. Every state register in the block is kept as three copies that are written together and read through a bitwise majority vote. A single upset copy is therefore outvoted.

Top module: `fast_cmd_rx`

## Requirements
- R1: A frame is the pattern 0xA5 followed by an 8-bit code, both sent most significant bit first, one bit per rising clock edge. A frame is found at any bit alignment, even when stray bits come before it. If the pattern is wrong, no strobe is issued.
- R2: The code table is 0x1E nudge, 0x2D calibrate, 0x4B sync, 0x78 swap and 0x87 chip reset. For a valid frame, exactly the matching strobe goes high. It goes high in the cycle after the edge that captures the last code bit, and it stays high for exactly one cycle.
- R3: A frame with a code outside the table issues no strobe. It leaves the channel select unchanged and does not disturb the divider phase.
- R4: After a frame is accepted, the bit history is cleared. Two frames sent back to back each produce their own single strobe.
- R5: The fast enable is a one-cycle pulse every 4 cycles, and the slow enable is a one-cycle pulse every 32 cycles. Both fire in the last state of the divider count. After reset is released, the first fast pulse is seen in cycle 3 and the first slow pulse in cycle 31.
- R6: In the cycle after the sync strobe, the divider count restarts at zero. The next slow pulse comes exactly 32 cycles after the sync strobe cycle.
- R7: In the cycle of the nudge strobe, the divider count holds for one cycle. The slow edge that follows therefore comes one cycle later than it otherwise would.
- R8: If the nudge strobe falls in the cycle where the slow pulse was due, that pulse (and the fast one) is pushed back by one cycle. It is not repeated.
- R9: The channel select output is 0 for primary and 1 for secondary. It toggles in the cycle after each swap strobe.
- R10: In the cycle after a chip reset strobe, the channel select returns to primary.
- R11: While reset is asserted, all strobes, both enables and the channel select are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 64 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_bit_i | input | 1 | Serial command line, sampled on rising edges |
| nudge_o | output | 1 | One-cycle strobe: slow edge moved later |
| calib_o | output | 1 | One-cycle strobe: calibration request |
| sync_o | output | 1 | One-cycle strobe: divider resynchronised |
| bus_swap_o | output | 1 | One-cycle strobe: control-bus channel swapped |
| chip_reset_o | output | 1 | One-cycle strobe: chip and control-bus slave reset |
| bus_sel_o | output | 1 | Active control-bus channel, 0 primary, 1 secondary |
| en_fast_o | output | 1 | Divide-by-4 clock enable pulse |
| en_slow_o | output | 1 | Divide-by-32 clock enable pulse |

## Verification
The collision that matters is a nudge strobe landing in the very cycle where the divider's final count would fire the slow and fast enables. To provoke it, the bench issues a sync to fix the phase. It then waits 16 cycles and sends a nudge frame, so that the nudge strobe coincides with count 31. The result is judged at the ports: the enables must be low in the strobe cycle, high in the next cycle, and low again after that, which shows the pulse was deferred rather than doubled.

// File: rtl/fcr_pkg.sv
`timescale 1ns/1ps
package fcr_pkg;
  localparam int CMD_W   = 8;
  localparam int NUM_CMD = 5;

  // Bit index of each action in the strobe vector
  typedef enum int {
    IDX_NUDGE = 0,
    IDX_CAL   = 1,
    IDX_SYNC  = 2,
    IDX_SWAP  = 3,
    IDX_RST   = 4
  } cmd_idx_e;

  localparam logic [CMD_W-1:0] CODE_NUDGE = 8'h1E;
  localparam logic [CMD_W-1:0] CODE_CAL   = 8'h2D;
  localparam logic [CMD_W-1:0] CODE_SYNC  = 8'h4B;
  localparam logic [CMD_W-1:0] CODE_SWAP  = 8'h78;
  localparam logic [CMD_W-1:0] CODE_RST   = 8'h87;

  // Maps a code to a one-hot action vector; unknown codes give zero
  function automatic logic [NUM_CMD-1:0] decode_cmd(input logic [CMD_W-1:0] code);
    logic [NUM_CMD-1:0] oh;
    oh = '0;
    case (code)
      CODE_NUDGE: oh[IDX_NUDGE] = 1'b1;
      CODE_CAL:   oh[IDX_CAL]   = 1'b1;
      CODE_SYNC:  oh[IDX_SYNC]  = 1'b1;
      CODE_SWAP:  oh[IDX_SWAP]  = 1'b1;
      CODE_RST:   oh[IDX_RST]   = 1'b1;
      default:    oh = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/fcr_tmr_reg.sv
`timescale 1ns/1ps
module fcr_tmr_reg #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int COPIES = 3;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else         q <= d_i;
    end
  end

  function automatic logic [W-1:0] vote(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  assign q_o = vote(g_copy[0].q, g_copy[1].q, g_copy[2].q);

  // redundancy guard: with no upset injected, all copies must agree
  copies_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_copy[0].q == g_copy[1].q) && (g_copy[1].q == g_copy[2].q));
endmodule

// File: rtl/fcr_deframer.sv
`timescale 1ns/1ps
module fcr_deframer
  import fcr_pkg::*;
#(
  parameter logic [CMD_W-1:0] PREAMBLE = 8'hA5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_i,
  output logic [NUM_CMD-1:0] strobe_o,
  output logic               frame_hit_o
);
  localparam int FRAME_W = 2 * CMD_W;
  localparam int HIST_W  = FRAME_W - 1;

  logic [HIST_W-1:0]  hist_q, hist_d;
  logic [FRAME_W-1:0] window;
  logic [NUM_CMD-1:0] code_oh, stb_d;

  // The newest bit completes the window in the same cycle it is sampled
  assign window      = {hist_q, bit_i};
  assign code_oh     = decode_cmd(window[CMD_W-1:0]);
  assign frame_hit_o = (window[FRAME_W-1:CMD_W] == PREAMBLE) && (|code_oh);
  assign hist_d      = frame_hit_o ? '0 : window[HIST_W-1:0];
  assign stb_d       = frame_hit_o ? code_oh : '0;

  fcr_tmr_reg #(.W(HIST_W)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hist_d), .q_o(hist_q));

  fcr_tmr_reg #(.W(NUM_CMD)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stb_d), .q_o(strobe_o));

  // R2
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |=> (strobe_o == '0));
  // R4
  hist_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_hit_o |=> (hist_q == '0) && (strobe_o != '0));
endmodule

// File: rtl/fcr_divider.sv
`timescale 1ns/1ps
module fcr_divider #(
  parameter int FAST_DIV = 4,   // power of two
  parameter int SLOW_DIV = 32   // power of two, multiple of FAST_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic hold_i,
  output logic en_fast_o,
  output logic en_slow_o
);
  localparam int               CNT_W     = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_MASK = CNT_W'(FAST_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Sync restarts the count, a nudge freezes it for one cycle
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic restart, input logic freeze);
    if (restart)     return '0;
    if (freeze)      return c;
    if (c == LAST)   return '0;
    return c + 1'b1;
  endfunction

  function automatic logic at_fast_edge(input logic [CNT_W-1:0] c);
    return (c & FAST_MASK) == FAST_MASK;
  endfunction

  assign cnt_d     = step_count(cnt_q, sync_i, hold_i);
  assign en_fast_o = at_fast_edge(cnt_q) && !hold_i;
  assign en_slow_o = (cnt_q == LAST) && !hold_i;

  fcr_tmr_reg #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_d), .q_o(cnt_q));

  // R5
  slow_in_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_slow_o |-> en_fast_o);
  // R6
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0));
  // R7
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !sync_i) |=> $stable(cnt_q));
  // R8
  slow_no_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_slow_o |=> !en_slow_o);
  // R8
  slow_deferred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !sync_i && cnt_q == LAST) |=> en_slow_o);
endmodule

// File: rtl/fast_cmd_rx.sv
`timescale 1ns/1ps
module fast_cmd_rx
  import fcr_pkg::*;
#(
  parameter logic [CMD_W-1:0] PREAMBLE = 8'hA5,
  parameter int               FAST_DIV = 4,
  parameter int               SLOW_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_bit_i,
  output logic nudge_o,
  output logic calib_o,
  output logic sync_o,
  output logic bus_swap_o,
  output logic chip_reset_o,
  output logic bus_sel_o,
  output logic en_fast_o,
  output logic en_slow_o
);
  logic [NUM_CMD-1:0] strobe;
  logic               frame_hit;
  logic               sel_d;

  fcr_deframer #(.PREAMBLE(PREAMBLE)) u_deframer (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(cmd_bit_i),
    .strobe_o(strobe), .frame_hit_o(frame_hit));

  fcr_divider #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_divider (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sync_i(strobe[IDX_SYNC]), .hold_i(strobe[IDX_NUDGE]),
    .en_fast_o(en_fast_o), .en_slow_o(en_slow_o));

  // Chip reset forces primary; a swap toggles the channel
  assign sel_d = strobe[IDX_RST]  ? 1'b0 :
                 strobe[IDX_SWAP] ? ~bus_sel_o : bus_sel_o;

  fcr_tmr_reg #(.W(1)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sel_d), .q_o(bus_sel_o));

  assign nudge_o      = strobe[IDX_NUDGE];
  assign calib_o      = strobe[IDX_CAL];
  assign sync_o       = strobe[IDX_SYNC];
  assign bus_swap_o   = strobe[IDX_SWAP];
  assign chip_reset_o = strobe[IDX_RST];

  // R9
  swap_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_swap_o |=> (bus_sel_o != $past(bus_sel_o)));
  // R10
  reset_primary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_reset_o |=> !bus_sel_o);
  // R3
  sel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_swap_o && !chip_reset_o) |=> $stable(bus_sel_o));
  // R2
  hit_to_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_hit |=> $countones({nudge_o, calib_o, sync_o, bus_swap_o, chip_reset_o}) == 1);
endmodule

// File: tb/tb_fast_cmd_rx.sv
`timescale 1ns/1ps
module tb_fast_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic nudge, calib, sync, swap, chip_rst, sel, en16, en2;
  logic [4:0] stb;

  localparam logic [7:0] PRE = 8'hA5;
  // one-hot strobe values as {reset, swap, sync, calibrate, nudge}
  localparam int S_NUDGE = 1, S_CAL = 2, S_SYNC = 4, S_SWAP = 8, S_RST = 16;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fast_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_bit_i(din),
    .nudge_o(nudge), .calib_o(calib), .sync_o(sync), .bus_swap_o(swap),
    .chip_reset_o(chip_rst), .bus_sel_o(sel), .en_fast_o(en16), .en_slow_o(en2));

  assign stb = {chip_rst, swap, sync, calib, nudge};

  task automatic check_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Called at a falling edge; returns at the falling edge of the strobe cycle
  task automatic send_frame(input logic [7:0] pre, input logic [7:0] code);
    logic [15:0] f;
    f = {pre, code};
    for (int i = 15; i >= 0; i--) begin
      din = f[i];
      step(1);
    end
    din = 1'b0;
  endtask

  task automatic cycles_to_en2(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (!en2 && n < 200);
  endtask

  task automatic t_reset;
    int first16, n;
    @(negedge clk);
    check_eq("R11 strobes in reset", int'(stb), 0);
    check_eq("R11 select in reset", int'(sel), 0);
    check_eq("R11 enables in reset", int'({en16, en2}), 0);
    step(2);
    rst_n = 1'b1;
    first16 = -1;
    n = 0;
    do begin
      step(1);
      n++;
      if (en16 && first16 < 0) first16 = n;
    end while (!en2 && n < 200);
    check_eq("R5 first fast pulse", first16, 3);
    check_eq("R5 first slow pulse", n, 31);
    step(4);
    check_eq("R5 fast period 4", int'(en16), 1);
    check_eq("R5 slow single cycle", int'(en2), 0);
  endtask

  task automatic t_sync;
    int n;
    send_frame(PRE, 8'h4B);
    check_eq("R2 sync strobe", int'(stb), S_SYNC);
    step(1);
    check_eq("R2 strobe one cycle", int'(stb), 0);
    cycles_to_en2(n);
    check_eq("R6 slow after sync", n + 1, 32);
    cycles_to_en2(n);
    check_eq("R5 slow period 32", n, 32);
  endtask

  task automatic t_nudge;
    int n;
    send_frame(PRE, 8'h4B);
    step(1);
    send_frame(PRE, 8'h1E);
    check_eq("R2 nudge strobe", int'(stb), S_NUDGE);
    cycles_to_en2(n);
    check_eq("R7 slow one cycle late", n, 16);
    cycles_to_en2(n);
    check_eq("R7 period restored", n, 32);
  endtask

  task automatic t_collide;
    send_frame(PRE, 8'h4B);
    step(16);
    send_frame(PRE, 8'h1E);
    check_eq("R8 nudge on wrap strobe", int'(stb), S_NUDGE);
    check_eq("R8 pulse withheld", int'({en16, en2}), 0);
    step(1);
    check_eq("R8 pulse deferred", int'({en16, en2}), 3);
    step(1);
    check_eq("R8 not doubled", int'(en2), 0);
  endtask

  task automatic t_swap_reset;
    send_frame(PRE, 8'h78);
    check_eq("R2 swap strobe", int'(stb), S_SWAP);
    check_eq("R9 select before", int'(sel), 0);
    step(1);
    check_eq("R9 select toggled", int'(sel), 1);
    send_frame(PRE, 8'h78);
    step(1);
    check_eq("R9 select toggled back", int'(sel), 0);
    send_frame(PRE, 8'h78);
    step(1);
    send_frame(PRE, 8'h87);
    check_eq("R2 reset strobe", int'(stb), S_RST);
    check_eq("R10 select before", int'(sel), 1);
    step(1);
    check_eq("R10 select primary", int'(sel), 0);
  endtask

  task automatic t_ignore;
    int n;
    send_frame(PRE, 8'h78);
    step(1);
    send_frame(PRE, 8'h4B);
    step(1);
    send_frame(PRE, 8'h55);
    check_eq("R3 unknown code no strobe", int'(stb), 0);
    step(1);
    check_eq("R3 unknown code no late strobe", int'(stb), 0);
    check_eq("R3 select kept", int'(sel), 1);
    cycles_to_en2(n);
    check_eq("R3 divider undisturbed", n, 14);
    send_frame(8'h5A, 8'h2D);
    check_eq("R1 wrong pattern ignored", int'(stb), 0);
    step(1);
    check_eq("R1 wrong pattern no late strobe", int'(stb), 0);
  endtask

  task automatic t_slip_b2b;
    din = 1'b1; step(1);
    din = 1'b0; step(1);
    din = 1'b1; step(1);
    send_frame(PRE, 8'h2D);
    check_eq("R1 found after stray bits", int'(stb), S_CAL);
    send_frame(PRE, 8'h78);
    check_eq("R4 back-to-back second strobe", int'(stb), S_SWAP);
    step(1);
    check_eq("R4 back-to-back quiet", int'(stb), 0);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_nudge();
    t_collide();
    t_swap_reset();
    t_ignore();
    t_slip_b2b();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule